// File: doc/BRIEF.md
# Color-Banked Host Register Port

This block is the register front end of a color scanner signal chain. A host processor reaches it over an 8-bit parallel bus with an active-low chip select, an active-low read strobe, an active-low write strobe and a 3-bit address. Eight addresses are decoded. Two of them hold global configuration words, one holds the Bayer mode control, one is reserved, and four hold registers that exist once per color channel. The stored values are exported as plain outputs to the correction datapath.

The per-color registers share one address each. A 2-bit color pointer, kept in the top two bits of the main configuration word, chooses which of the red, green or blue copies a host write lands in. It also chooses which copy a host read returns. To load a full set of coefficients, the host first sets the pointer and then writes the per-color addresses. It repeats this for each color.

The strobes are sampled on the system clock. A write is taken when the write strobe goes from low to high while chip select is low. Reads are combinational while both chip select and the read strobe are low. At all other times the bus is released.

Top module: `hostreg_color_port`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears every stored register to zero, so all value outputs, bayer_on, scale_en, split_sel and color_ptr read zero afterwards.
- R2: A write is committed at the first clock edge that sees wr_n high after an edge that saw it low, provided cs_n is low at that edge; a write strobe pulse with cs_n high changes nothing.
- R3: Addresses decode as 0 = main configuration, 1 = configuration 2, 2 = gain, 3 = odd offset, 4 = even offset, 5 = input offset, 6 = reserved, 7 = Bayer control.
- R4: Main configuration bits 7:6 appear on color_ptr, bits 5:3 on split_sel and bits 2:0 on scale_en.
- R5: Pointer code 00 selects red (copy 0), 01 green (copy 1) and 10 blue (copy 2); a write to a per-color address updates only the selected copy, and the other copies keep their values.
- R6: With pointer code 11, writes to addresses 2 to 5 change no copy.
- R7: A read of addresses 2 to 5 returns the copy chosen by the current pointer, and returns zero when the pointer is 11.
- R8: host_d is driven only while both cs_n and rd_n are low; otherwise the block leaves the bus undriven.
- R9: Address 6 reads as zero, and writes to it change no register.
- R10: Writes to address 7 store bit 0 only; bayer_on follows that bit, and a read of address 7 returns it in bit 0 with the other bits zero.
- R11: Configuration 2 is a single global 8-bit register that reads back exactly as written, whatever the pointer is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; a write is taken on its rising edge |
| addr | input | 3 | Register address |
| host_d | inout | DATA_W | Bidirectional host data bus |
| scale_en | output | 3 | Digital scaling enables from the main configuration |
| split_sel | output | 3 | Gain/offset split selects from the main configuration |
| color_ptr | output | 2 | Current color pointer |
| cfg2_q | output | DATA_W | Configuration 2 value |
| gain_q | output | NUM_COLORS*DATA_W | Gain copies, red in the lowest slice |
| odd_off_q | output | NUM_COLORS*DATA_W | Odd-pixel offset copies |
| even_off_q | output | NUM_COLORS*DATA_W | Even-pixel offset copies |
| in_off_q | output | NUM_COLORS*DATA_W | Input offset copies |
| bayer_on | output | 1 | Bayer mode enable |

## Verification
The bench builds the block with DATA_W = 8 and NUM_COLORS = 3. With these values the pointer space is 2 bits wide and has four codes, and the address space has eight locations. The bench therefore sweeps every pointer code against every per-color address, and that includes the unused code 11. After each write it compares all twelve exported copies against an arithmetic model. It also reads back all eight addresses under every pointer, which covers the reserved slot, the Bayer bit masking and the retention of copies that the current pointer does not select.

// File: rtl/hcp_pkg.sv
package hcp_pkg;
   typedef enum logic [2:0] {
      ADR_CFG   = 3'd0,
      ADR_CFG2  = 3'd1,
      ADR_GAIN  = 3'd2,
      ADR_ODD   = 3'd3,
      ADR_EVEN  = 3'd4,
      ADR_INOFF = 3'd5,
      ADR_RSVD  = 3'd6,
      ADR_BAYER = 3'd7
   } hcp_addr_e;

   typedef enum logic [1:0] {
      CLR_RED   = 2'd0,
      CLR_GREEN = 2'd1,
      CLR_BLUE  = 2'd2,
      CLR_NONE  = 2'd3
   } hcp_color_e;

   localparam int unsigned NUM_BANKED = 4;
   localparam int unsigned FIRST_BANKED = 2;
endpackage

// File: rtl/hcp_strobe.sv
module hcp_strobe (
   input  logic clk,
   input  logic rst,
   input  logic cs_n,
   input  logic rd_n,
   input  logic wr_n,
   output logic wr_pulse,
   output logic rd_oe
);
   logic wr_q;

   always_ff @(posedge clk) begin
      if (rst) wr_q <= 1'b1;
      else     wr_q <= wr_n;
   end

   assign wr_pulse = wr_n & ~wr_q & ~cs_n;
   assign rd_oe    = ~cs_n & ~rd_n;

   // R2
   wr_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      wr_pulse |=> !wr_pulse);
endmodule

// File: rtl/hcp_color_bank.sv
module hcp_color_bank #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned NUM_COLORS = 3
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           wr_en,
   input  logic [1:0]                     ptr,
   input  logic [DATA_W-1:0]              wdata,
   output logic [NUM_COLORS*DATA_W-1:0]   q_flat,
   output logic [DATA_W-1:0]              rd_sel
);
   logic [DATA_W-1:0] copy_q [NUM_COLORS];

   for (genvar c = 0; c < NUM_COLORS; c++) begin : g_copy
      always_ff @(posedge clk) begin
         if (rst)                         copy_q[c] <= '0;
         else if (wr_en && ptr == 2'(c))  copy_q[c] <= wdata;
      end
      assign q_flat[c*DATA_W +: DATA_W] = copy_q[c];

      // R5
      other_copy_hold_chk: assert property (@(posedge clk) disable iff (rst)
         (wr_en && ptr != 2'(c)) |=> $stable(q_flat[c*DATA_W +: DATA_W]));
   end

   always_comb begin
      rd_sel = '0;
      for (int c = 0; c < NUM_COLORS; c++)
         if (ptr == 2'(c)) rd_sel = copy_q[c];
   end

   // R6
   bad_ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && ptr == 2'b11) |=> $stable(q_flat));
endmodule

// File: rtl/hcp_readmux.sv
module hcp_readmux
   import hcp_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic [2:0]                   addr,
   input  logic [DATA_W-1:0]            cfg_q,
   input  logic [DATA_W-1:0]            cfg2_q,
   input  logic                         bayer_q,
   input  logic [NUM_BANKED*DATA_W-1:0] bank_rd,
   output logic [DATA_W-1:0]            rdata
);
   always_comb begin
      unique case (hcp_addr_e'(addr))
         ADR_CFG:   rdata = cfg_q;
         ADR_CFG2:  rdata = cfg2_q;
         ADR_GAIN:  rdata = bank_rd[0*DATA_W +: DATA_W];
         ADR_ODD:   rdata = bank_rd[1*DATA_W +: DATA_W];
         ADR_EVEN:  rdata = bank_rd[2*DATA_W +: DATA_W];
         ADR_INOFF: rdata = bank_rd[3*DATA_W +: DATA_W];
         ADR_RSVD:  rdata = '0;
         ADR_BAYER: rdata = {{(DATA_W-1){1'b0}}, bayer_q};
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/hostreg_color_port.sv
module hostreg_color_port
   import hcp_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned NUM_COLORS = 3
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         cs_n,
   input  logic                         rd_n,
   input  logic                         wr_n,
   input  logic [2:0]                   addr,
   inout  wire  [DATA_W-1:0]            host_d,
   output logic [2:0]                   scale_en,
   output logic [2:0]                   split_sel,
   output logic [1:0]                   color_ptr,
   output logic [DATA_W-1:0]            cfg2_q,
   output logic [NUM_COLORS*DATA_W-1:0] gain_q,
   output logic [NUM_COLORS*DATA_W-1:0] odd_off_q,
   output logic [NUM_COLORS*DATA_W-1:0] even_off_q,
   output logic [NUM_COLORS*DATA_W-1:0] in_off_q,
   output logic                         bayer_on
);
   localparam int unsigned BANK_BITS = NUM_COLORS * DATA_W;

   if (DATA_W < 8) begin : g_bad_width
      $error("hostreg_color_port: DATA_W must be at least 8");
   end
   if (NUM_COLORS < 1 || NUM_COLORS > 3) begin : g_bad_colors
      $error("hostreg_color_port: NUM_COLORS must be 1 to 3");
   end

   logic                         wr_pulse, rd_oe;
   logic [DATA_W-1:0]            cfg_q, cfg2_r, rdata, wdata;
   logic                         bayer_q;
   logic [NUM_BANKED*DATA_W-1:0] bank_rd;
   logic [BANK_BITS-1:0]         bank_q [NUM_BANKED];

   assign wdata = host_d;

   hcp_strobe u_strobe (
      .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .wr_pulse(wr_pulse), .rd_oe(rd_oe)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q   <= '0;
         cfg2_r  <= '0;
         bayer_q <= 1'b0;
      end else if (wr_pulse) begin
         case (hcp_addr_e'(addr))
            ADR_CFG:   cfg_q   <= wdata;
            ADR_CFG2:  cfg2_r  <= wdata;
            ADR_BAYER: bayer_q <= wdata[0];
            default:   ;
         endcase
      end
   end

   for (genvar k = 0; k < NUM_BANKED; k++) begin : g_bank
      logic bank_we;
      assign bank_we = wr_pulse && (addr == 3'(FIRST_BANKED + k));
      hcp_color_bank #(.DATA_W(DATA_W), .NUM_COLORS(NUM_COLORS)) u_bank (
         .clk(clk), .rst(rst), .wr_en(bank_we), .ptr(cfg_q[7:6]),
         .wdata(wdata), .q_flat(bank_q[k]),
         .rd_sel(bank_rd[k*DATA_W +: DATA_W])
      );
   end

   hcp_readmux #(.DATA_W(DATA_W)) u_rmux (
      .addr(addr), .cfg_q(cfg_q), .cfg2_q(cfg2_r), .bayer_q(bayer_q),
      .bank_rd(bank_rd), .rdata(rdata)
   );

   assign host_d     = rd_oe ? rdata : 'z;
   assign scale_en   = cfg_q[2:0];
   assign split_sel  = cfg_q[5:3];
   assign color_ptr  = cfg_q[7:6];
   assign cfg2_q     = cfg2_r;
   assign gain_q     = bank_q[0];
   assign odd_off_q  = bank_q[1];
   assign even_off_q = bank_q[2];
   assign in_off_q   = bank_q[3];
   assign bayer_on   = bayer_q;

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (cfg_q == '0 && cfg2_r == '0 && !bayer_q && gain_q == '0 && in_off_q == '0));

   // R2
   no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_pulse |=> ($stable(cfg_q) && $stable(cfg2_r) && $stable(bayer_q) && $stable(gain_q)));

   // R9
   rsvd_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_pulse && addr == ADR_RSVD) |=> ($stable(cfg_q) && $stable(cfg2_r) && $stable(odd_off_q)
                                         && $stable(even_off_q) && $stable(bayer_q)));
endmodule

// File: tb/sim_hostreg_color_port.sv
module sim_hostreg_color_port;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [2:0] addr = 3'd0;
   logic       tb_oe = 1'b0;
   logic [7:0] tb_d = 8'd0;
   wire  [7:0] bus;
   logic [2:0] scale_en, split_sel;
   logic [1:0] color_ptr;
   logic [7:0] cfg2_q;
   logic [23:0] gain_q, odd_off_q, even_off_q, in_off_q;
   logic       bayer_on;

   int checks = 0, fails = 0;
   bit done = 0;

   logic [7:0] m_cfg, m_cfg2;
   logic       m_bay;
   logic [7:0] m_bank [4][3];

   assign bus = tb_oe ? tb_d : 'z;
   always #10 clk = ~clk;

   hostreg_color_port #(.DATA_W(8), .NUM_COLORS(3)) u0 (
      .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
      .host_d(bus), .scale_en(scale_en), .split_sel(split_sel), .color_ptr(color_ptr),
      .cfg2_q(cfg2_q), .gain_q(gain_q), .odd_off_q(odd_off_q), .even_off_q(even_off_q),
      .in_off_q(in_off_q), .bayer_on(bayer_on)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] act_bank(input int r, input int c);
      case (r)
         0:       return gain_q[c*8 +: 8];
         1:       return odd_off_q[c*8 +: 8];
         2:       return even_off_q[c*8 +: 8];
         default: return in_off_q[c*8 +: 8];
      endcase
   endfunction

   function automatic logic [7:0] exp_read(input int a);
      case (a)
         0: return m_cfg;
         1: return m_cfg2;
         2, 3, 4, 5: return (m_cfg[7:6] == 2'b11) ? 8'h00 : m_bank[a-2][m_cfg[7:6]];
         6: return 8'h00;
         default: return {7'b0, m_bay};
      endcase
   endfunction

   task automatic model_clear();
      m_cfg = 0; m_cfg2 = 0; m_bay = 0;
      for (int r = 0; r < 4; r++) for (int c = 0; c < 3; c++) m_bank[r][c] = 0;
   endtask

   task automatic model_write(input int a, input logic [7:0] d);
      case (a)
         0: m_cfg = d;
         1: m_cfg2 = d;
         2, 3, 4, 5: if (m_cfg[7:6] != 2'b11) m_bank[a-2][m_cfg[7:6]] = d;
         7: m_bay = d[0];
         default: ;
      endcase
   endtask

   task automatic check_outputs(input string req);
      chk({req, " R4 scale_en"}, 32'(scale_en), 32'(m_cfg[2:0]));
      chk({req, " R4 split_sel"}, 32'(split_sel), 32'(m_cfg[5:3]));
      chk({req, " R4 color_ptr"}, 32'(color_ptr), 32'(m_cfg[7:6]));
      chk({req, " R11 cfg2"}, 32'(cfg2_q), 32'(m_cfg2));
      chk({req, " R10 bayer_on"}, 32'(bayer_on), 32'(m_bay));
      for (int r = 0; r < 4; r++)
         for (int c = 0; c < 3; c++)
            chk($sformatf("%s R5 bank%0d color%0d", req, r, c), 32'(act_bank(r, c)), 32'(m_bank[r][c]));
   endtask

   task automatic host_write(input int a, input logic [7:0] d, input bit sel);
      @(negedge clk);
      cs_n = !sel; addr = 3'(a); tb_d = d; tb_oe = 1'b1; wr_n = 1'b0;
      @(negedge clk);
      wr_n = 1'b1;
      @(negedge clk);
      cs_n = 1'b1; tb_oe = 1'b0;
      if (sel) model_write(a, d);
   endtask

   task automatic host_read(input int a, output logic [7:0] v);
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b0; addr = 3'(a);
      #2 v = bus;
      rd_n = 1'b1; cs_n = 1'b1;
   endtask

   task automatic read_all(input string req);
      logic [7:0] v;
      for (int a = 0; a < 8; a++) begin
         host_read(a, v);
         chk($sformatf("%s R7 R3 addr %0d", req, a), 32'(v), 32'(exp_read(a)));
      end
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      model_clear();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      check_outputs("R1 reset");
      read_all("R1 reset");

      // R5 R6 R7 sweep: every pointer code against every banked address
      for (int p = 0; p < 4; p++) begin
         host_write(0, {2'(p), 6'(p * 9 + 5)}, 1'b1);
         for (int r = 0; r < 4; r++) begin
            host_write(2 + r, 8'(p * 37 + r * 11 + 1), 1'b1);
            check_outputs(p == 3 ? "R6 ptr11" : "R5 steer");
         end
         read_all("R7 sweep");
      end
      // R7 retention: revisit every pointer and read all copies
      for (int p = 0; p < 4; p++) begin
         host_write(0, {2'(p), 6'(p + 2)}, 1'b1);
         read_all("R7 revisit");
      end

      // R11 configuration 2 global
      host_write(1, 8'hC3, 1'b1);
      check_outputs("R11");
      host_write(0, 8'h40, 1'b1);
      host_read(1, v);
      chk("R11 cfg2 read", 32'(v), 32'h0C3);

      // R10 bayer bit
      host_write(7, 8'hFF, 1'b1);
      check_outputs("R10 on");
      host_read(7, v);
      chk("R10 read on", 32'(v), 32'h01);
      host_write(7, 8'hFE, 1'b1);
      check_outputs("R10 off");
      host_read(7, v);
      chk("R10 read off", 32'(v), 32'h00);
      host_write(7, 8'h01, 1'b1);

      // R9 reserved
      host_write(6, 8'hFF, 1'b1);
      check_outputs("R9 rsvd write");
      host_read(6, v);
      chk("R9 rsvd read", 32'(v), 32'h00);

      // R2 strobe without chip select
      host_write(1, 8'h5A, 1'b0);
      host_write(3, 8'h77, 1'b0);
      check_outputs("R2 cs high");
      read_all("R2 cs high");

      // R8 bus released: bench drives a pattern while the block must stay off
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b1; addr = 3'd1; tb_d = 8'h3C; tb_oe = 1'b1;
      #2 chk("R8 rd high", 32'(bus), 32'h03C);
      cs_n = 1'b1; rd_n = 1'b0;
      #2 chk("R8 cs high", 32'(bus), 32'h03C);
      rd_n = 1'b1; tb_oe = 1'b0;

      // R1 reset after activity
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      model_clear();
      check_outputs("R1 mid-run");
      read_all("R1 mid-run");

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule